// File: doc/BRIEF.md
# Gradual Cache Key Remap Controller

This controller manages the two keys that scramble the set mapping of a shared cache, so that lines that would collide under one key scatter under another. It never swaps keys in one bulk step. It relocates one set at a time, after a fixed number of cache accesses. A set pointer marks how far the move has progressed. For every access, the pointer decides whether the current key or the next key applies.

The cache presents each access as a one-cycle strobe. With the strobe it gives the set index computed under the current key. The controller answers in the same cycle with a key-select bit and with the per-line key bit that a fill should store. There is no back-pressure on accesses: every strobe is accepted. When enough accesses have been counted, the controller raises a remap request that names the set to relocate. It holds the request until the line mover pulses done.

When the pointer passes the last set, an epoch ends. The next key becomes current, and a fresh next key is taken from an internal LFSR. The sense of the per-line key bit also inverts, so no line needs rewriting. New LFSR state can be written through a valid/ready port. The port drops ready only in the cycle an epoch ends. While ready is low, the offered word is not taken and must be held.

Top module: `gkr_ctrl`

## Requirements
- R1: After reset the following values hold: remap_set is 0, remap_req is 0, cur_key equals KEY0, nxt_key equals KEY1, key_sense is 0, and key_in_ready is 1.
- R2: use_next is 1 exactly when acc_set is below remap_set, comparing both as unsigned numbers, in the same cycle.
- R3: fill_key_bit equals key_sense when use_next is 0, and equals the inverse of key_sense when use_next is 1.
- R4: When no request is pending, the WAYS*ACCESS_MULT-th counted access raises remap_req on the next clock edge, with remap_set naming the set at the pointer. The access counter then restarts from zero.
- R5: remap_req and remap_set stay unchanged until remap_done is sampled high. On that edge remap_req falls and remap_set advances by one.
- R6: Accesses that arrive while a request is pending are still counted. The count saturates at the threshold, and a second request is never raised. If the count is saturated when done arrives, the new request rises exactly one cycle after remap_req fell.
- R7: A done for set SETS-1 does four things on the same edge: remap_set returns to 0, cur_key takes the old nxt_key, nxt_key takes the LFSR state, and key_sense inverts.
- R8: At every epoch end the LFSR steps to the value (s<<1) XOR (TAPS if bit KEY_W-1 of s is set). A handshake on key_in (valid and ready both high) replaces the LFSR state with key_in_data.
- R9: key_in_ready is 0 only in a cycle where remap_req, remap_done and remap_set==SETS-1 all hold. A word offered in that cycle is not taken.
- R10: remap_done is ignored while no request is pending: remap_set and the keys stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | One-cycle cache access strobe |
| acc_set | input | SET_W | Set index of the access under the current key |
| use_next | output | 1 | The access must use the next key |
| fill_key_bit | output | 1 | Key bit to store with a line filled by this access |
| remap_req | output | 1 | A set relocation is requested |
| remap_set | output | SET_W | Set to relocate, which is also the set pointer |
| remap_done | input | 1 | The mover has finished the requested set |
| key_in_valid | input | 1 | A new LFSR state is offered |
| key_in_ready | output | 1 | The offered state can be taken this cycle |
| key_in_data | input | KEY_W | New LFSR state |
| cur_key | output | KEY_W | Key in force for sets at or above the pointer |
| nxt_key | output | KEY_W | Key in force for sets below the pointer |
| key_sense | output | 1 | Stored key bit value that denotes the current key |

## Verification
The set-index comparison is tried in two ways. Indices below, equal to and above the pointer are used, and each is checked at several pointer positions, so an off-by-one or a signed comparison stands out. The access count is tried with two patterns. A run one access short of the threshold separates early firing from correct firing, and a burst during a pending request separates saturation from a duplicate request or a lost deferred request. Done pulses are given both with and without a pending request. Two full epochs are run, one with a reloaded LFSR word and one with a word offered during the epoch-end cycle, which shows whether rotation, sense inversion, LFSR stepping and the refused load all happen on the right edge.

// File: rtl/gkr_pkg.sv
package gkr_pkg;
  // Events shared between the pointer and the key store in one cycle
  typedef struct packed {
    logic accept;  // pending request completed this cycle
    logic wrap;    // completion of the last set: epoch ends
  } gkr_evt_t;
endpackage

// File: rtl/gkr_access_counter.sv
module gkr_access_counter #(
  parameter int CNT_W = 16,
  parameter int RATE  = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic req_pending,
  output logic issue
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RATE);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  // counting stops at the threshold while a request is outstanding
  always_comb begin
    cnt_inc = cnt_q;
    if (acc_valid && (cnt_q < LIMIT)) cnt_inc = cnt_q + 1'b1;
  end

  assign issue = !req_pending && (cnt_inc == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (issue) cnt_q <= '0;
    else            cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/gkr_set_pointer.sv
module gkr_set_pointer
  import gkr_pkg::*;
#(
  parameter int SET_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             done_in,
  output logic             req,
  output logic [SET_W-1:0] ptr,
  output gkr_evt_t         evt
);
  assign evt.accept = req && done_in;
  assign evt.wrap   = evt.accept && (ptr == {SET_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      ptr <= '0;
    end else if (evt.accept) begin
      req <= 1'b0;
      ptr <= ptr + 1'b1;  // natural wrap to zero past the last set
    end else if (issue) begin
      req <= 1'b1;
    end
  end
endmodule

// File: rtl/gkr_key_store.sv
module gkr_key_store
  import gkr_pkg::*;
#(
  parameter int             KEY_W = 40,
  parameter logic [KEY_W-1:0] KEY0  = 40'h5A3C_96E1_07,
  parameter logic [KEY_W-1:0] KEY1  = 40'hC3_1F_2B_8D_44,
  parameter logic [KEY_W-1:0] SEED  = 40'h00_0000_0001,
  parameter logic [KEY_W-1:0] TAPS  = 40'hA0_0014_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gkr_evt_t         evt,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [KEY_W-1:0] load_data,
  output logic [KEY_W-1:0] cur,
  output logic [KEY_W-1:0] nxt,
  output logic             sense
);
  logic [KEY_W-1:0] lfsr_q;
  logic [KEY_W-1:0] lfsr_step;

  assign lfsr_step  = {lfsr_q[KEY_W-2:0], 1'b0} ^ (lfsr_q[KEY_W-1] ? TAPS : '0);
  assign load_ready = !evt.wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= KEY0;
      nxt    <= KEY1;
      lfsr_q <= SEED;
      sense  <= 1'b0;
    end else if (evt.wrap) begin
      cur    <= nxt;
      nxt    <= lfsr_q;
      lfsr_q <= lfsr_step;
      sense  <= ~sense;
    end else if (load_valid) begin
      lfsr_q <= load_data;
    end
  end
endmodule

// File: rtl/gkr_ctrl.sv
module gkr_ctrl
  import gkr_pkg::*;
#(
  parameter int               SETS         = 1024,
  parameter int               WAYS         = 16,
  parameter int               ACCESS_MULT  = 100,
  parameter int               CNT_W        = 16,
  parameter int               KEY_W        = 40,
  parameter logic [KEY_W-1:0] KEY0         = 40'h5A3C_96E1_07,
  parameter logic [KEY_W-1:0] KEY1         = 40'hC3_1F_2B_8D_44,
  parameter logic [KEY_W-1:0] SEED         = 40'h00_0000_0001,
  parameter logic [KEY_W-1:0] TAPS         = 40'hA0_0014_0000,
  localparam int              SET_W        = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  output logic             use_next,
  output logic             fill_key_bit,
  output logic             remap_req,
  output logic [SET_W-1:0] remap_set,
  input  logic             remap_done,
  input  logic             key_in_valid,
  output logic             key_in_ready,
  input  logic [KEY_W-1:0] key_in_data,
  output logic [KEY_W-1:0] cur_key,
  output logic [KEY_W-1:0] nxt_key,
  output logic             key_sense
);
  localparam int RATE = WAYS * ACCESS_MULT;

  logic     issue;
  gkr_evt_t evt;

  gkr_access_counter #(.CNT_W(CNT_W), .RATE(RATE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .req_pending(remap_req), .issue(issue)
  );

  gkr_set_pointer #(.SET_W(SET_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .issue(issue), .done_in(remap_done),
    .req(remap_req), .ptr(remap_set), .evt(evt)
  );

  gkr_key_store #(
    .KEY_W(KEY_W), .KEY0(KEY0), .KEY1(KEY1), .SEED(SEED), .TAPS(TAPS)
  ) u_keys (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .load_valid(key_in_valid && key_in_ready), .load_ready(key_in_ready),
    .load_data(key_in_data), .cur(cur_key), .nxt(nxt_key), .sense(key_sense)
  );

  // sets below the pointer have already moved under the next key
  assign use_next     = acc_set < remap_set;
  assign fill_key_bit = key_sense ^ use_next;
endmodule

// File: rtl/gkr_ctrl_checks.sv
module gkr_ctrl_checks #(
  parameter int SET_W = 10,
  parameter int KEY_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             remap_req,
  input logic             remap_done,
  input logic [SET_W-1:0] remap_set,
  input logic [KEY_W-1:0] cur_key,
  input logic [KEY_W-1:0] nxt_key,
  input logic             key_sense
);
  logic last_done;
  assign last_done = remap_req && remap_done && (remap_set == {SET_W{1'b1}});

  a_r5_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    remap_req && !remap_done |=> remap_req && $stable(remap_set));

  a_r5_advance_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    remap_req && remap_done |=> !remap_req && (remap_set == SET_W'($past(remap_set) + 1'b1)));

  a_r7_rotate_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> (cur_key == $past(nxt_key)) && (key_sense != $past(key_sense)));

  a_r7_keys_still_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !last_done |=> $stable(cur_key) && $stable(key_sense));

  a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !remap_req |=> $stable(remap_set));
endmodule

bind gkr_ctrl gkr_ctrl_checks #(.SET_W(SET_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .remap_req(remap_req), .remap_done(remap_done),
  .remap_set(remap_set), .cur_key(cur_key), .nxt_key(nxt_key), .key_sense(key_sense)
);

// File: tb/gkr_ctrl_tb.sv
module gkr_ctrl_tb;
  localparam int SETS = 4;
  localparam int SW   = 2;
  localparam int KW   = 40;
  localparam int RATE = 4;  // WAYS=2 * ACCESS_MULT=2
  localparam logic [KW-1:0] K0   = 40'h00_0000_00A1;
  localparam logic [KW-1:0] K1   = 40'h00_0000_00B2;
  localparam logic [KW-1:0] TP   = 40'hA0_0014_0000;
  localparam logic [KW-1:0] KNEW = 40'h80_0000_1234;
  localparam logic [KW-1:0] KBAD = 40'h00_0BAD_0BAD;

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, remap_done = 0, key_in_valid = 0;
  logic [SW-1:0] acc_set = '0;
  logic [KW-1:0] key_in_data = '0;
  logic use_next, fill_key_bit, remap_req, key_in_ready, key_sense;
  logic [SW-1:0] remap_set;
  logic [KW-1:0] cur_key, nxt_key;

  int checks = 0, errors = 0;
  int exp_ptr = 0;
  logic exp_sense = 0;
  int req_q[$];
  logic prev_req = 0;

  always #4 clk = ~clk;  // 125 MHz

  gkr_ctrl #(.SETS(SETS), .WAYS(2), .ACCESS_MULT(2), .KEY0(K0), .KEY1(K1),
             .SEED(40'h1), .TAPS(TP)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .use_next(use_next), .fill_key_bit(fill_key_bit), .remap_req(remap_req),
    .remap_set(remap_set), .remap_done(remap_done), .key_in_valid(key_in_valid),
    .key_in_ready(key_in_ready), .key_in_data(key_in_data), .cur_key(cur_key),
    .nxt_key(nxt_key), .key_sense(key_sense)
  );

  function automatic logic [KW-1:0] step(input logic [KW-1:0] s);
    return {s[KW-2:0], 1'b0} ^ (s[KW-1] ? TP : '0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: every rising request is matched against the scoreboard
  initial forever begin
    @(negedge clk);
    if (rst_n && remap_req && !prev_req) begin
      if (req_q.size() == 0) chk("R6 unexpected request", 1, 0);
      else chk("R4 requested set", 64'(remap_set), 64'(req_q.pop_front()));
    end
    prev_req = remap_req;
  end

  // drive one access; key select is checked against the bench pointer
  task automatic access(input int s);
    logic en;
    acc_valid = 1; acc_set = SW'(s);
    en = (s < exp_ptr);
    @(negedge clk);
    chk("R2 use_next", 64'(use_next), 64'(en));
    chk("R3 fill_key_bit", 64'(fill_key_bit), 64'(exp_sense ^ en));
    @(posedge clk); #1 acc_valid = 0;
  endtask

  task automatic done_pulse();
    remap_done = 1;
    @(posedge clk); #1 remap_done = 0;
  endtask

  task automatic finish_set();
    done_pulse();
    exp_ptr = (exp_ptr + 1) % SETS;
    if (exp_ptr == 0) exp_sense = ~exp_sense;
    @(negedge clk);
    chk("R5 req falls on done", 64'(remap_req), 0);
    chk("R5 pointer advance", 64'(remap_set), 64'(exp_ptr));
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 remap_set", 64'(remap_set), 0);
    chk("R1 remap_req", 64'(remap_req), 0);
    chk("R1 cur_key", cur_key, K0);
    chk("R1 nxt_key", nxt_key, K1);
    chk("R1 key_sense", 64'(key_sense), 0);
    chk("R1 key_in_ready", 64'(key_in_ready), 1);
    @(posedge clk); #1;

    // R4: one short of the threshold, then the threshold
    for (int i = 0; i < RATE - 1; i++) access(i);
    @(negedge clk); chk("R4 no early request", 64'(remap_req), 0);
    @(posedge clk); #1;
    req_q.push_back(0);
    access(2);
    @(negedge clk); chk("R4 request raised", 64'(remap_req), 1);
    // R5: held without done
    repeat (3) begin
      @(negedge clk);
      chk("R5 request held", 64'(remap_req), 1);
      chk("R5 set stable", 64'(remap_set), 0);
    end
    @(posedge clk); #1;
    finish_set();

    // R2/R3 around pointer 1: below, equal, above
    access(0); access(1); access(3);
    // R10: done with nothing pending
    done_pulse();
    @(negedge clk);
    chk("R10 pointer unchanged", 64'(remap_set), 1);
    chk("R10 cur_key unchanged", cur_key, K0);
    @(posedge clk); #1;

    // R6: saturate during a pending request
    req_q.push_back(1);
    access(2);
    repeat (5) access(0);
    @(negedge clk); chk("R6 single request", 64'(req_q.size()), 0);
    @(posedge clk); #1;
    req_q.push_back(2);
    finish_set();  // leaves us one cycle later, at posedge+1
    @(negedge clk);
    chk("R6 deferred request", 64'(remap_req), 1);
    @(posedge clk); #1;
    finish_set();

    // R8: load a new LFSR state
    key_in_valid = 1; key_in_data = KNEW;
    @(negedge clk); chk("R9 ready when idle", 64'(key_in_ready), 1);
    @(posedge clk); #1 key_in_valid = 0;
    req_q.push_back(3);
    for (int i = 0; i < RATE; i++) access(3);

    // R7/R9: epoch end with a refused load in the same cycle
    remap_done = 1; key_in_valid = 1; key_in_data = KBAD;
    @(negedge clk); chk("R9 ready low at epoch end", 64'(key_in_ready), 0);
    @(posedge clk); #1 remap_done = 0; key_in_valid = 0;
    exp_ptr = 0; exp_sense = 1;
    @(negedge clk);
    chk("R7 pointer wraps", 64'(remap_set), 0);
    chk("R7 cur takes next", cur_key, K1);
    chk("R8 next takes loaded state", nxt_key, KNEW);
    chk("R7 sense inverts", 64'(key_sense), 1);
    @(posedge clk); #1;
    access(0);  // R3 with inverted sense

    // second epoch
    for (int s = 0; s < SETS; s++) begin
      req_q.push_back(s);
      for (int i = 0; i < ((s == 0) ? RATE - 1 : RATE); i++) access((s + 2) % SETS);
      @(negedge clk); chk("R4 request in epoch two", 64'(remap_req), 1);
      @(posedge clk); #1;
      finish_set();
    end
    @(negedge clk);
    chk("R7 cur after second epoch", cur_key, KNEW);
    chk("R8 LFSR step, R9 refused word", nxt_key, step(KNEW));
    chk("R7 sense back to zero", 64'(key_sense), 0);
    finish_run();
  end
endmodule